// File: doc/BRIEF.md
# Level-Interrupt GPIO Port

A general-purpose I/O port of `W` pins (32 by default) with its own interrupt front end. A word-addressed read/write bus reaches two register windows, chosen by a window-select input. The port window holds four registers: pin direction, output data, interrupt polarity and interrupt status. The interrupt window holds a read-only pending view of the status bits and a mask register.

Every pin is sampled through a two-flop synchronizer. On each clock, a pin whose synchronized value equals its selected active level sets its status bit. Software clears status bits by writing zeros. Writing a word that is all ones except for one zero clears a single pin. Status bits that are pending and not masked are ORed into one registered parent interrupt line. After reset, every source is masked until software enables it.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are all zeros, `irq_out` is 0, the mask register reads all ones, the direction register reads zero and the polarity register reads all ones.
- R2: A write to port-window offset 0x00 sets the direction register, and a 1 bit makes that pin an output. A write to port-window offset 0x04 sets the output data. On the next clock, `pin_oe` and `pin_out` show the written words, and both registers read back through the bus.
- R3: A read of port-window offset 0x04 returns the driven output value for pins whose direction bit is 1. For all other pins it returns `pin_in` as seen after the two-flop synchronizer.
- R4: Port-window offset 0x08 holds the polarity. A 1 bit makes that pin active-high and a 0 bit makes it active-low. A status bit becomes 1 on the clock after the synchronized pin matches its active level.
- R5: A write to port-window offset 0x0C clears every status bit written as 0 and leaves every bit written as 1 unchanged. If a pin still sits at its active level, its bit is set again in the same clock, so the bit stays 1.
- R6: A read of interrupt-window offset 0x00 returns the status bits. Writes to that offset have no effect.
- R7: Interrupt-window offset 0x08 is the mask, and a 1 bit blocks that pin. `irq_out` is a register that is 1 exactly when, on the previous clock, some status bit was 1 with its mask bit 0.
- R8: A read of interrupt-window offset 0x04 or 0x0C returns zero. Writes there change no register.
- R9: Read data appears on `bus_rdata` on the clock after `bus_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_win | input | 1 | Window select: 0 selects the port window, 1 selects the interrupt window |
| bus_addr | input | 4 | Byte offset inside the window; bits 3:2 pick the word |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid one cycle after `bus_rd` |
| pin_in | input | W | Asynchronous pin levels |
| pin_out | output | W | Output drive values |
| pin_oe | output | W | Output enables (1 = drive) |
| irq_out | output | 1 | Combined parent interrupt |

## Verification
The assertions assume that strobes and addresses are driven synchronously and are held low during reset, so that no write lands before the first clocked check. They also assume that a pin stays at one level across the two synchronizer stages before status is judged. The stimulus changes bus inputs only on the falling clock edge and holds each `pin_in` value for several cycles before it reads or checks anything that depends on it. Under these conditions the status and interrupt latencies are fixed at three and four clocks from a pin change.

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_win,
  input  logic [3:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         irq_out
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] dir_q, out_q, lvl_q, stat_q, mask_q, s1_q, s2_q;
  logic [W-1:0] lvl_hit, keep, rd_mux;

  wire [1:0] word  = bus_addr[3:2];
  wire       wr_pt = bus_wr && !bus_win;
  wire       wr_ir = bus_wr && bus_win;

  assign lvl_hit = ~(s2_q ^ lvl_q);
  assign keep    = (wr_pt && word == 2'd3) ? bus_wdata : ONES;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    rd_mux = '0;
    if (!bus_win) begin
      case (word)
        2'd0: rd_mux = dir_q;
        2'd1: rd_mux = (dir_q & out_q) | (~dir_q & s2_q);
        2'd2: rd_mux = lvl_q;
        2'd3: rd_mux = stat_q;
      endcase
    end else begin
      case (word)
        2'd0:    rd_mux = stat_q;
        2'd2:    rd_mux = mask_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q     <= '0;
      out_q     <= '0;
      lvl_q     <= ONES;
      stat_q    <= '0;
      mask_q    <= ONES;
      s1_q      <= '0;
      s2_q      <= '0;
      irq_out   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      stat_q <= (stat_q & keep) | lvl_hit;
      irq_out <= |(stat_q & ~mask_q);
      bus_rdata <= bus_rd ? rd_mux : '0;
      if (wr_pt && word == 2'd0) dir_q  <= bus_wdata;
      if (wr_pt && word == 2'd1) out_q  <= bus_wdata;
      if (wr_pt && word == 2'd2) lvl_q  <= bus_wdata;
      if (wr_ir && word == 2'd2) mask_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/gpio_lvl_irq_chk.sv
module gpio_lvl_irq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_win,
  input logic [3:0]   bus_addr,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic         irq_out,
  input logic [W-1:0] stat_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] lvl_hit
);
  wire wr_dir  = bus_wr && !bus_win && bus_addr[3:2] == 2'd0;
  wire wr_dat  = bus_wr && !bus_win && bus_addr[3:2] == 2'd1;
  wire wr_stat = bus_wr && !bus_win && bus_addr[3:2] == 2'd3;
  wire rd_hole = bus_rd && bus_win && bus_addr[2];
  wire live    = |(stat_q & ~mask_q);

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(bus_wdata));
  assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> pin_out == $past(bus_wdata));
  assert_level_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(lvl_hit) & ~stat_q) == '0);
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (stat_q & ~$past(bus_wdata) & ~$past(lvl_hit)) == '0);
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> irq_out);
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !irq_out);
  assert_hole_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hole |=> bus_rdata == '0);
endmodule

bind gpio_lvl_irq gpio_lvl_irq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_out(irq_out), .stat_q(stat_q), .mask_q(mask_q), .lvl_hit(lvl_hit)
);

// File: tb/gpio_lvl_irq_bench.sv
module gpio_lvl_irq_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_win = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic         irq_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  gpio_lvl_irq #(.W(W)) u_gpio_lvl_irq (
    .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic win, logic [3:0] a, logic [W-1:0] d);
    @(negedge clk);
    bus_win = win; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic win, logic [3:0] a, logic [W-1:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_win = win; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        #1;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9 unexpected read actual=%h expected=none", bus_rdata);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 irq_out", {31'd0, irq_out}, '0);
    rd(1'b1, 4'h8, 32'hFFFF_FFFF, "R1 mask reset");
    rd(1'b0, 4'h0, 32'h0, "R1 dir reset");
    rd(1'b0, 4'h8, 32'hFFFF_FFFF, "R1 R4 level reset");
    rd(1'b0, 4'hC, 32'h0, "R4 no status with low pins");

    wr(1'b0, 4'h0, 32'h0000_00FF);
    wr(1'b0, 4'h4, 32'hA5A5_A5A5);
    check("R2 pin_oe", pin_oe, 32'h0000_00FF);
    check("R2 pin_out", pin_out, 32'hA5A5_A5A5);
    rd(1'b0, 4'h0, 32'h0000_00FF, "R2 dir readback");

    pin_in = 32'h0000_0E3C;
    idle(5);
    rd(1'b0, 4'h4, 32'h0000_0EA5, "R3 data mixes out and pins");
    rd(1'b0, 4'hC, 32'h0000_0E3C, "R4 active-high status");
    rd(1'b1, 4'h0, 32'h0000_0E3C, "R6 pending view");
    check("R7 all masked irq", {31'd0, irq_out}, '0);

    wr(1'b1, 4'h8, 32'hFFFF_FDFF);
    idle(1);
    check("R7 unmasked irq", {31'd0, irq_out}, 1);

    wr(1'b0, 4'hC, 32'hFFFF_FDFF);
    idle(1);
    rd(1'b0, 4'hC, 32'h0000_0E3C, "R5 asserted bit re-sets");

    pin_in = 32'h0000_0C3C;
    idle(5);
    rd(1'b0, 4'hC, 32'h0000_0E3C, "R5 sticky after release");
    wr(1'b0, 4'hC, 32'hFFFF_FFFF);
    rd(1'b0, 4'hC, 32'h0000_0E3C, "R5 ones keep");
    wr(1'b0, 4'hC, 32'hFFFF_FDFF);
    idle(1);
    rd(1'b0, 4'hC, 32'h0000_0C3C, "R5 one-pin clear");
    check("R7 irq drops", {31'd0, irq_out}, '0);

    wr(1'b0, 4'h8, 32'hFFFF_FDFF);
    idle(2);
    rd(1'b0, 4'hC, 32'h0000_0E3C, "R4 active-low status");
    check("R4 R7 irq active-low", {31'd0, irq_out}, 1);

    wr(1'b1, 4'h0, 32'h0);
    rd(1'b1, 4'h0, 32'h0000_0E3C, "R6 pending write ignored");

    rd(1'b1, 4'h4, 32'h0, "R8 hole 0x04");
    rd(1'b1, 4'hC, 32'h0, "R8 hole 0x0C");
    wr(1'b1, 4'h4, 32'h0);
    wr(1'b1, 4'hC, 32'h0);
    rd(1'b1, 4'h8, 32'hFFFF_FDFF, "R8 mask untouched");
    check("R8 irq unchanged", {31'd0, irq_out}, 1);

    idle(2);
    check("R9 read queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule